// File: doc/BRIEF.md
# Interlaced Video Raster Timing Generator

This block produces the pixel and line counters of an interlaced standard-definition raster. It supports two line standards: a 525-line frame and a 625-line frame. For each of them it supports two horizontal sampling grids, rectangular or square pixels. A pixel-rate enable advances the counters. A synchronous reset restarts the frame at its first pixel.

Downstream logic receives the current pixel index, the current line number, a flag telling which field is being scanned, and a registered qualifier. The qualifier is high only on pixels that fall inside the active window of an active line. The standard and grid selections are sampled only at a frame boundary, so a frame is never split between two geometries. Sync shaping, porches, analog levels and timing-code insertion belong to other blocks.

Top module: `vid_raster_gen`

## Requirements
- R1: `pix_cnt` counts 0, 1, ... up to the line total minus one and then returns to 0. It advances only on clock edges where `pix_en` is high and holds otherwise.
- R2: `line_cnt` counts from 1 up to the frame total (525 when `sel_625`=0, 625 when `sel_625`=1) and then returns to 1. It advances only on the edge where `pix_cnt` wraps.
- R3: The line total in pixels is 858 for 525-line rectangular (`sel_625`=0, `sel_square`=0), 780 for 525-line square (`sel_square`=1), 864 for 625-line rectangular, and 944 for 625-line square.
- R4: The active pixel count is 720 for both rectangular grids, 640 for 525-line square and 768 for 625-line square. The active pixels are the last ones of the line, starting at index total minus active.
- R5: In the 525-line standard the active lines are 23 to 262 and 285 to 524. Lines 1 to 22, 263 to 284 and 525 are blanked, which gives 480 active lines per frame.
- R6: In the 625-line standard the active lines are 23 to 310 and 336 to 623. Lines 1 to 22, 311 to 335, 624 and 625 are blanked, which gives 576 active lines per frame.
- R7: `field_even` is 0 from line 1 up to the line before 263 (525-line standard) or before 311 (625-line standard), and 1 from that line to the end of the frame.
- R8: `sel_625` and `sel_square` take effect only when the frame wraps from its last pixel to line 1, pixel 0, or at reset. A change in the middle of a frame does not alter the current frame.
- R9: `active_video` is registered and describes the same pixel and line that `pix_cnt` and `line_cnt` show in that cycle.
- R10: While `rst` is sampled high, the next state is `pix_cnt`=0, `line_cnt`=1 and `active_video`=0, and the selections are loaded from the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pix_en | input | 1 | Pixel-rate advance enable |
| sel_625 | input | 1 | 1 selects the 625-line standard, 0 selects the 525-line standard |
| sel_square | input | 1 | 1 selects square-pixel sampling |
| pix_cnt | output | PIX_W | Current pixel index within the line |
| line_cnt | output | LINE_W | Current line number within the frame |
| field_even | output | 1 | 1 while the second (even) field is scanned |
| active_video | output | 1 | High on active pixels of active lines |

## Verification
A corrupted pixel or line counter shows on the ports in the next enabled cycle. It appears as a wrong index, and then as a wrong wrap point, which moves every later window edge. A stale or prematurely loaded selection first shows at the next line end, where the wrap point no longer matches the total the bench expects. A wrong window decode shows as a qualifier edge that is off by one pixel or one line from its expected boundary. The bench compares every output on every clock against a behavioural model. It uses a full-size instance for the pixel windows and a second instance with short lines, so that whole frames, field changes and mid-frame selection changes fit in the run.

// File: rtl/raster_pkg.sv
package raster_pkg;

  typedef struct packed {
    logic std625;
    logic square;
  } raster_cfg_t;

  localparam int LINES_525     = 525;
  localparam int LINES_625     = 625;
  localparam int ODD_FIRST     = 23;
  localparam int ODD_LAST_525  = 262;
  localparam int EVEN_BLANK_525 = 263;
  localparam int EVEN_FIRST_525 = 285;
  localparam int EVEN_LAST_525 = 524;
  localparam int ODD_LAST_625  = 310;
  localparam int EVEN_BLANK_625 = 311;
  localparam int EVEN_FIRST_625 = 336;
  localparam int EVEN_LAST_625 = 623;

  function automatic int frame_lines(input logic std625);
    return std625 ? LINES_625 : LINES_525;
  endfunction

  function automatic int even_start(input logic std625);
    return std625 ? EVEN_BLANK_625 : EVEN_BLANK_525;
  endfunction

  function automatic logic line_on(input logic std625, input int ln);
    if (std625)
      return ((ln >= ODD_FIRST) && (ln <= ODD_LAST_625)) ||
             ((ln >= EVEN_FIRST_625) && (ln <= EVEN_LAST_625));
    return ((ln >= ODD_FIRST) && (ln <= ODD_LAST_525)) ||
           ((ln >= EVEN_FIRST_525) && (ln <= EVEN_LAST_525));
  endfunction

  // choose one of four values by standard and grid
  function automatic int pick4(input raster_cfg_t c, input int r525, input int s525,
                               input int r625, input int s625);
    if (c.std625) return c.square ? s625 : r625;
    return c.square ? s525 : r525;
  endfunction

endpackage

// File: rtl/raster_hcount.sv
module raster_hcount #(
  parameter int PIX_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  input  logic [PIX_W-1:0] total,
  output logic [PIX_W-1:0] pix_q,
  output logic [PIX_W-1:0] pix_nxt,
  output logic             line_end
);

  assign line_end = (pix_q == total - 1'b1);

  always_comb begin
    pix_nxt = pix_q;
    if (adv) pix_nxt = line_end ? '0 : pix_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) pix_q <= '0;
    else     pix_q <= pix_nxt;
  end

  // R1
  pix_range_chk: assert property (@(posedge clk) disable iff (rst)
    pix_q < total);

  // R1
  pix_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(pix_q));

endmodule

// File: rtl/raster_vcount.sv
module raster_vcount #(
  parameter int LINE_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv,
  input  logic [LINE_W-1:0] last_line,
  output logic [LINE_W-1:0] line_q,
  output logic [LINE_W-1:0] line_nxt,
  output logic              frame_last
);

  assign frame_last = (line_q == last_line);

  always_comb begin
    line_nxt = line_q;
    if (adv) line_nxt = frame_last ? LINE_W'(1) : line_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) line_q <= LINE_W'(1);
    else     line_q <= line_nxt;
  end

  // R2
  line_range_chk: assert property (@(posedge clk) disable iff (rst)
    (line_q >= LINE_W'(1)) && (line_q <= last_line));

  // R2
  line_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(line_q));

endmodule

// File: rtl/raster_window.sv
module raster_window
  import raster_pkg::*;
#(
  parameter int PIX_W  = 10,
  parameter int LINE_W = 10
) (
  input  raster_cfg_t       cfg,
  input  logic [PIX_W-1:0]  pix,
  input  logic [PIX_W-1:0]  first_active,
  input  logic [LINE_W-1:0] line,
  output logic              in_window,
  output logic              even_field
);

  always_comb begin
    in_window  = (pix >= first_active) && line_on(cfg.std625, int'(line));
    even_field = int'(line) >= even_start(cfg.std625);
  end

endmodule

// File: rtl/vid_raster_gen.sv
module vid_raster_gen
  import raster_pkg::*;
#(
  parameter int PIX_W        = 10,
  parameter int LINE_W       = 10,
  parameter int TOT_525_RECT = 858,
  parameter int ACT_525_RECT = 720,
  parameter int TOT_525_SQ   = 780,
  parameter int ACT_525_SQ   = 640,
  parameter int TOT_625_RECT = 864,
  parameter int ACT_625_RECT = 720,
  parameter int TOT_625_SQ   = 944,
  parameter int ACT_625_SQ   = 768
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pix_en,
  input  logic              sel_625,
  input  logic              sel_square,
  output logic [PIX_W-1:0]  pix_cnt,
  output logic [LINE_W-1:0] line_cnt,
  output logic              field_even,
  output logic              active_video
);

  raster_cfg_t       cfg_q, cfg_in, cfg_nxt;
  logic [PIX_W-1:0]  tot_cur, start_cur, start_nxt, pix_q, pix_nxt;
  logic [LINE_W-1:0] last_cur, line_q, line_nxt;
  logic              line_end, frame_last, line_step, frame_wrap;
  logic              act_nxt, act_q, win_cur, unused_even_nxt;

  function automatic logic [PIX_W-1:0] total_of(input raster_cfg_t c);
    return PIX_W'(pick4(c, TOT_525_RECT, TOT_525_SQ, TOT_625_RECT, TOT_625_SQ));
  endfunction

  function automatic logic [PIX_W-1:0] start_of(input raster_cfg_t c);
    return PIX_W'(pick4(c, TOT_525_RECT - ACT_525_RECT, TOT_525_SQ - ACT_525_SQ,
                        TOT_625_RECT - ACT_625_RECT, TOT_625_SQ - ACT_625_SQ));
  endfunction

  assign cfg_in     = '{std625: sel_625, square: sel_square};
  assign tot_cur    = total_of(cfg_q);
  assign start_cur  = start_of(cfg_q);
  assign last_cur   = LINE_W'(frame_lines(cfg_q.std625));
  assign line_step  = pix_en & line_end;
  assign frame_wrap = line_step & frame_last;
  assign cfg_nxt    = frame_wrap ? cfg_in : cfg_q;
  assign start_nxt  = start_of(cfg_nxt);

  raster_hcount #(.PIX_W(PIX_W)) u_h (
    .clk(clk), .rst(rst), .adv(pix_en), .total(tot_cur),
    .pix_q(pix_q), .pix_nxt(pix_nxt), .line_end(line_end)
  );

  raster_vcount #(.LINE_W(LINE_W)) u_v (
    .clk(clk), .rst(rst), .adv(line_step), .last_line(last_cur),
    .line_q(line_q), .line_nxt(line_nxt), .frame_last(frame_last)
  );

  // decode of the state about to be entered
  raster_window #(.PIX_W(PIX_W), .LINE_W(LINE_W)) u_wn (
    .cfg(cfg_nxt), .pix(pix_nxt), .first_active(start_nxt), .line(line_nxt),
    .in_window(act_nxt), .even_field(unused_even_nxt)
  );

  // decode of the state currently shown
  raster_window #(.PIX_W(PIX_W), .LINE_W(LINE_W)) u_wc (
    .cfg(cfg_q), .pix(pix_q), .first_active(start_cur), .line(line_q),
    .in_window(win_cur), .even_field(field_even)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= cfg_in;
      act_q <= 1'b0;
    end else begin
      cfg_q <= cfg_nxt;
      act_q <= act_nxt;
    end
  end

  assign pix_cnt      = pix_q;
  assign line_cnt     = line_q;
  assign active_video = act_q;

  // R8
  cfg_frame_only_chk: assert property (@(posedge clk) disable iff (rst)
    !frame_wrap |=> $stable(cfg_q));

  // R9
  act_aligned_chk: assert property (@(posedge clk) disable iff (rst)
    active_video == win_cur);

  // R7
  field_edge_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(field_even) |-> (int'(line_q) == even_start(cfg_q.std625)));

  // R10
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (pix_cnt == '0) && (line_cnt == LINE_W'(1)) && !active_video);

  // R2
  frame_start_chk: assert property (@(posedge clk) disable iff (rst)
    frame_wrap |=> (line_cnt == LINE_W'(1)) && (pix_cnt == '0) && !field_even);

endmodule

// File: tb/vid_raster_gen_tb_top.sv
module vid_raster_gen_tb_top;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pix_en = 1'b0;
  logic sel_625 = 1'b0;
  logic sel_square = 1'b0;
  int   vectors = 0;
  int   fails = 0;
  bit   gate_en = 1'b0;

  always #5 clk = ~clk;

  logic [9:0] o_pix [2];
  logic [9:0] o_line [2];
  logic       o_fld [2];
  logic       o_act [2];

  vid_raster_gen dut_i (
    .clk(clk), .rst(rst), .pix_en(pix_en), .sel_625(sel_625), .sel_square(sel_square),
    .pix_cnt(o_pix[0]), .line_cnt(o_line[0]), .field_even(o_fld[0]), .active_video(o_act[0])
  );

  // short lines so that whole frames fit in the run
  vid_raster_gen #(
    .TOT_525_RECT(12), .ACT_525_RECT(8), .TOT_525_SQ(10), .ACT_525_SQ(6),
    .TOT_625_RECT(14), .ACT_625_RECT(8), .TOT_625_SQ(16), .ACT_625_SQ(10)
  ) dut_s (
    .clk(clk), .rst(rst), .pix_en(pix_en), .sel_625(sel_625), .sel_square(sel_square),
    .pix_cnt(o_pix[1]), .line_cnt(o_line[1]), .field_even(o_fld[1]), .active_video(o_act[1])
  );

  // ---- behavioural reference ----
  int m_pix [2];
  int m_line [2];
  bit m_std [2];
  bit m_sq [2];
  bit m_act [2];

  function automatic int tb_tot(input int k, input bit s, input bit q);
    if (k == 0) return s ? (q ? 944 : 864) : (q ? 780 : 858);   // R3
    return s ? (q ? 16 : 14) : (q ? 10 : 12);
  endfunction

  function automatic int tb_act(input int k, input bit s, input bit q);
    if (k == 0) return s ? (q ? 768 : 720) : (q ? 640 : 720);   // R4
    return s ? (q ? 10 : 8) : (q ? 6 : 8);
  endfunction

  function automatic bit tb_line_on(input bit s, input int l);
    if (s) return (l >= 23 && l <= 310) || (l >= 336 && l <= 623);  // R6
    return (l >= 23 && l <= 262) || (l >= 285 && l <= 524);         // R5
  endfunction

  always @(posedge clk) begin
    for (int k = 0; k < 2; k++) begin
      if (rst) begin
        m_pix[k] = 0; m_line[k] = 1; m_act[k] = 1'b0;
        m_std[k] = sel_625; m_sq[k] = sel_square;
      end else if (pix_en) begin
        if (m_pix[k] == tb_tot(k, m_std[k], m_sq[k]) - 1) begin
          m_pix[k] = 0;
          if (m_line[k] == (m_std[k] ? 625 : 525)) begin
            m_line[k] = 1;
            m_std[k] = sel_625; m_sq[k] = sel_square;   // R8
          end else begin
            m_line[k] = m_line[k] + 1;
          end
        end else begin
          m_pix[k] = m_pix[k] + 1;
        end
        m_act[k] = (m_pix[k] >= tb_tot(k, m_std[k], m_sq[k]) - tb_act(k, m_std[k], m_sq[k]))
                   && tb_line_on(m_std[k], m_line[k]);  // R9
      end
    end
  end

  always @(negedge clk) begin
    if (gate_en) begin
      for (int k = 0; k < 2; k++) begin
        bit bad;
        bit m_fld;
        bad = 1'b0;
        m_fld = (m_line[k] >= (m_std[k] ? 311 : 263));
        vectors++;
        if (int'(o_pix[k]) != m_pix[k]) begin
          bad = 1'b1;
          $display("FAIL R1 R3 inst%0d pix actual %0d expected %0d", k, o_pix[k], m_pix[k]);
        end
        if (int'(o_line[k]) != m_line[k]) begin
          bad = 1'b1;
          $display("FAIL R2 R8 inst%0d line actual %0d expected %0d", k, o_line[k], m_line[k]);
        end
        if (o_fld[k] != m_fld) begin
          bad = 1'b1;
          $display("FAIL R7 inst%0d field actual %0d expected %0d line %0d", k, o_fld[k], m_fld, m_line[k]);
        end
        if (o_act[k] != m_act[k]) begin
          bad = 1'b1;
          $display("FAIL R4 R5 R6 R9 inst%0d active actual %0d expected %0d at line %0d pix %0d",
                   k, o_act[k], m_act[k], m_line[k], m_pix[k]);
        end
        if (bad) fails++;
      end
    end
  end

  task automatic do_reset(input bit s, input bit q);
    @(negedge clk);
    rst = 1'b1; sel_625 = s; sel_square = q;
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic run(input int n, input bit gated);
    for (int i = 0; i < n; i++) begin
      pix_en = gated ? ((i % 7) != 6) : 1'b1;
      @(negedge clk);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    gate_en = 1'b1;
    // R10 reset state, visible while rst is held
    @(negedge clk);
    for (int k = 0; k < 2; k++) begin
      vectors++;
      if (o_pix[k] != 0 || o_line[k] != 1 || o_act[k] != 1'b0) begin
        fails++;
        $display("FAIL R10 inst%0d reset state actual pix %0d line %0d act %0d expected 0 1 0",
                 k, o_pix[k], o_line[k], o_act[k]);
      end
    end
    rst = 1'b0;
    // whole frames of the short-line instance in every mode, gated enable
    for (int m = 0; m < 4; m++) begin
      bit s;
      bit q;
      s = m[1]; q = m[0];
      do_reset(s, q);
      run(tb_tot(1, s, q) * (s ? 625 : 525) * 7 / 6 + 200, 1'b1);
    end
    // R8 selection change in the middle of a frame
    do_reset(1'b0, 1'b0);
    run(3000, 1'b1);
    sel_625 = 1'b1; sel_square = 1'b1;
    run(12 * 525 * 7 / 6 + 16 * 40, 1'b1);
    sel_625 = 1'b0; sel_square = 1'b1;
    run(16 * 625 * 7 / 6 + 200, 1'b1);
    // full-size lines: window edges of the first active lines in every mode
    for (int m = 0; m < 4; m++) begin
      bit s;
      bit q;
      s = m[1]; q = m[0];
      do_reset(s, q);
      run(tb_tot(0, s, q) * 24 + 10, 1'b0);
    end
    finish_run();
  end

  initial begin
    repeat (199000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

endmodule